// File: doc/BRIEF.md
# Overlapping Speech Frame Preprocessor

This block turns a slow stream of 12-bit signed audio samples into overlapping analysis frames of 200 samples. Each new frame starts 80 samples after the previous one. The samples are kept in a ring store, so every frame reuses the newest 120 samples of the one before it. Once a frame is complete, the block makes two passes over the stored samples. The first pass adds up the 200 samples and turns the sum into a fixed-point mean. The second pass subtracts that mean from each sample, adds the square of each mean-removed sample into an energy total, and sends each sample through a first-order pre-emphasis filter.

The input side has no ready signal because the sampling converter cannot be stalled, so every `in_valid` beat is stored. The output side is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the beat is held unchanged, and the second pass pauses until the beat is taken. The frame energy and a one-cycle `frame_done` strobe are plain outputs. The environment must keep the time needed to process a frame shorter than the time taken by 80 input samples. At 8 kS/s this is a 10 ms budget.

Top module: `frame_preproc`

## Requirements
- R1: No output beat and no `frame_done` appear until 200 samples have been accepted since reset. After that, each further group of 80 accepted samples produces exactly one frame, and that frame's `frame_done` arrives before the next group of 80 is complete.
- R2: Frame k (counting from 0 after reset) is made of accepted samples 80k through 80k+199, in arrival order. Samples that arrive while a frame is being processed are stored and do not change that frame's results.
- R3: The frame mean, in Q8 format, is floor((S·83886 + 32768) / 65536), where S is the signed sum of the frame's 200 raw samples. The constant 83886 is 2^24/200 rounded down.
- R4: Each mean-removed sample is s(n) = x(n)·256 − mean, where x(n) is the raw sample. The result has 8 fractional bits.
- R5: `energy` equals the sum over the frame of s(n)², an unsigned value with 16 fractional bits. It updates in the same cycle that `frame_done` is high and holds its value in every other cycle.
- R6: The output stream carries 200 beats per frame, in the order n = 0…199. Each beat is y(n) = s(n) − floor((248·s(n−1) + 128) / 256), where s(−1) = 0. The value is a 24-bit two's complement number in Q15.8 format.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value in the next cycle.
- R8: `frame_done` is high for exactly one cycle per frame. That cycle is the first cycle in which the frame's last beat (n = 199) is presented with `out_valid` high.
- R9: After reset, `out_valid`, `frame_done` and `energy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input sample is present in this cycle |
| in_sample | input | 12 | Signed raw sample |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | The consumer accepts the current output beat |
| out_data | output | 24 | Pre-emphasized sample, signed Q15.8 |
| energy | output | 52 | Sum of squared mean-removed samples, Q16 |
| frame_done | output | 1 | One-cycle strobe at the end of a frame |

## Verification
Some rules are checked by assertions on every cycle: the output beat holds still under back-pressure, `frame_done` lasts a single cycle and coincides with a valid beat, `energy` does not change between strobes, and no frame is reported before the first 200 samples have been accepted. Other properties can only be shown by the bench scenarios, which compare against a sample-by-sample arithmetic model. These are the exact numbers: the rounded mean, every filtered beat, and the energy total. They also include the frame boundaries with their 120-sample reuse, correct results while new samples keep arriving during processing, and a restart of the priming count after a reset in mid-stream.

// File: rtl/frame_preproc_pkg.sv
package frame_preproc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUM  = 2'd1,
    ST_MEAN = 2'd2,
    ST_EMIT = 2'd3
  } fp_state_e;
endpackage

// File: rtl/fp_sample_ring.sv
module fp_sample_ring #(
  parameter int SAMPLE_W  = 12,
  parameter int FRAME_LEN = 200,
  parameter int HOP       = 80
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [SAMPLE_W-1:0]           in_sample,
  input  logic [$clog2(FRAME_LEN)-1:0]  rd_idx,
  output logic [SAMPLE_W-1:0]           rd_data,
  output logic                          frame_go
);
  localparam int DEPTH = FRAME_LEN + HOP;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam int HOP_W = $clog2(HOP);

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, ptr_nxt, base_q, base_nxt;
  logic [IDX_W-1:0]    fill_cnt;
  logic [HOP_W-1:0]    hop_cnt;
  logic                primed;
  logic [PTR_W:0]      addr_sum, addr_wrap;

  always_comb begin
    ptr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
    if (ptr_nxt >= PTR_W'(FRAME_LEN)) base_nxt = ptr_nxt - PTR_W'(FRAME_LEN);
    else                              base_nxt = ptr_nxt + PTR_W'(HOP);
  end

  always_ff @(posedge clk) begin
    if (in_valid) mem[wr_ptr] <= in_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      fill_cnt <= '0;
      hop_cnt  <= '0;
      primed   <= 1'b0;
      base_q   <= '0;
      frame_go <= 1'b0;
    end else begin
      frame_go <= 1'b0;
      if (in_valid) begin
        wr_ptr <= ptr_nxt;
        if (!primed) begin
          if (fill_cnt == IDX_W'(FRAME_LEN - 1)) begin
            primed   <= 1'b1;
            frame_go <= 1'b1;
            base_q   <= base_nxt;
          end else begin
            fill_cnt <= fill_cnt + IDX_W'(1);
          end
        end else if (hop_cnt == HOP_W'(HOP - 1)) begin
          hop_cnt  <= '0;
          frame_go <= 1'b1;
          base_q   <= base_nxt;
        end else begin
          hop_cnt <= hop_cnt + HOP_W'(1);
        end
      end
    end
  end

  always_comb begin
    addr_sum  = {1'b0, base_q} + (PTR_W+1)'(rd_idx);
    addr_wrap = (addr_sum >= (PTR_W+1)'(DEPTH)) ? addr_sum - (PTR_W+1)'(DEPTH) : addr_sum;
    rd_data   = mem[addr_wrap[PTR_W-1:0]];
  end
endmodule

// File: rtl/fp_frame_engine.sv
module fp_frame_engine
  import frame_preproc_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int FRAME_LEN = 200,
  parameter int FRAC_W    = 8,
  parameter int OUT_W     = 24,
  parameter int COEF_Q8   = 248,
  parameter int RECIP_SH  = 24,
  parameter int MR_W      = SAMPLE_W + FRAC_W + 2,
  parameter int ENERGY_W  = 2 * (SAMPLE_W + FRAC_W + 2) + $clog2(FRAME_LEN)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_go,
  input  logic [SAMPLE_W-1:0]          rd_data,
  output logic [$clog2(FRAME_LEN)-1:0] rd_idx,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [OUT_W-1:0]             out_data,
  output logic [ENERGY_W-1:0]          energy,
  output logic                         frame_done
);
  localparam int IDX_W  = $clog2(FRAME_LEN);
  localparam int ACC_W  = SAMPLE_W + IDX_W;
  localparam int PROD_W = ACC_W + RECIP_SH + 2;
  localparam int PE_W   = MR_W + 10;
  localparam int SQ_W   = 2 * MR_W;
  localparam longint RECIP = ((64'sd1 <<< RECIP_SH) + FRAME_LEN / 2) / FRAME_LEN;
  localparam int MEAN_SH = RECIP_SH - FRAC_W;

  fp_state_e state;
  logic [IDX_W-1:0]         idx;
  logic signed [ACC_W-1:0]  acc;
  logic signed [MR_W-1:0]   mean_q, prev_q;
  logic [ENERGY_W-1:0]      eacc;

  logic signed [ACC_W-1:0]  raw_ext;
  logic signed [PROD_W-1:0] mean_prod, mean_sh;
  logic signed [MR_W-1:0]   x_q8, s_cur;
  logic signed [PE_W-1:0]   pe_prod, pe_sh;
  logic signed [MR_W:0]     y_cur;
  logic signed [SQ_W-1:0]   sq;
  logic                     last_idx, slot_free;

  assign rd_idx    = idx;
  assign last_idx  = (idx == IDX_W'(FRAME_LEN - 1));
  assign slot_free = !out_valid || out_ready;

  always_comb begin
    raw_ext   = ACC_W'($signed(rd_data));
    mean_prod = PROD_W'(acc) * $signed(PROD_W'(RECIP));
    mean_sh   = (mean_prod + $signed(PROD_W'(64'd1 << (MEAN_SH - 1)))) >>> MEAN_SH;
    x_q8      = MR_W'($signed({rd_data, FRAC_W'(0)}));
    s_cur     = x_q8 - mean_q;
    pe_prod   = PE_W'(prev_q) * $signed(PE_W'(COEF_Q8));
    pe_sh     = (pe_prod + $signed(PE_W'(64'd1 << (FRAC_W - 1)))) >>> FRAC_W;
    y_cur     = (MR_W+1)'(s_cur) - pe_sh[MR_W:0];
    sq        = SQ_W'(s_cur) * SQ_W'(s_cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      acc        <= '0;
      mean_q     <= '0;
      prev_q     <= '0;
      eacc       <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      energy     <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (frame_go) begin
            state <= ST_SUM;
            idx   <= '0;
            acc   <= '0;
          end
        end
        ST_SUM: begin
          acc <= acc + raw_ext;
          if (last_idx) begin
            state <= ST_MEAN;
            idx   <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_MEAN: begin
          mean_q <= mean_sh[MR_W-1:0];
          prev_q <= '0;
          eacc   <= '0;
          state  <= ST_EMIT;
        end
        ST_EMIT: begin
          if (slot_free) begin
            out_valid <= 1'b1;
            out_data  <= OUT_W'(y_cur);
            prev_q    <= s_cur;
            if (last_idx) begin
              energy     <= eacc + ENERGY_W'($unsigned(sq));
              frame_done <= 1'b1;
              state      <= ST_IDLE;
              idx        <= '0;
            end else begin
              eacc <= eacc + ENERGY_W'($unsigned(sq));
              idx  <= idx + IDX_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_preproc.sv
module frame_preproc #(
  parameter int SAMPLE_W  = 12,
  parameter int FRAME_LEN = 200,
  parameter int HOP       = 80,
  parameter int FRAC_W    = 8,
  parameter int OUT_W     = 24,
  parameter int COEF_Q8   = 248,
  parameter int RECIP_SH  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUT_W-1:0]    out_data,
  output logic [2*(SAMPLE_W+FRAC_W+2)+$clog2(FRAME_LEN)-1:0] energy,
  output logic                frame_done
);
  localparam int IDX_W    = $clog2(FRAME_LEN);
  localparam int MR_W     = SAMPLE_W + FRAC_W + 2;
  localparam int ENERGY_W = 2 * MR_W + IDX_W;

  logic [IDX_W-1:0]    rd_idx;
  logic [SAMPLE_W-1:0] rd_data;
  logic                frame_go;

  fp_sample_ring #(
    .SAMPLE_W (SAMPLE_W),
    .FRAME_LEN(FRAME_LEN),
    .HOP      (HOP)
  ) ring_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .frame_go (frame_go)
  );

  fp_frame_engine #(
    .SAMPLE_W (SAMPLE_W),
    .FRAME_LEN(FRAME_LEN),
    .FRAC_W   (FRAC_W),
    .OUT_W    (OUT_W),
    .COEF_Q8  (COEF_Q8),
    .RECIP_SH (RECIP_SH),
    .MR_W     (MR_W),
    .ENERGY_W (ENERGY_W)
  ) engine_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_go  (frame_go),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .energy    (energy),
    .frame_done(frame_done)
  );
endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
  parameter int FRAME_LEN = 200,
  parameter int OUT_W     = 24,
  parameter int ENERGY_W  = 52
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                out_valid,
  input logic                out_ready,
  input logic [OUT_W-1:0]    out_data,
  input logic [ENERGY_W-1:0] energy,
  input logic                frame_done
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != CNT_W'(FRAME_LEN)) seen <= seen + CNT_W'(1);
  end

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R8

  AST_DONE_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> out_valid); // R8

  AST_ENERGY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(energy)); // R5

  AST_NO_EARLY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done || out_valid) |-> (seen == CNT_W'(FRAME_LEN))); // R1
endmodule

bind frame_preproc fp_checker #(
  .FRAME_LEN(FRAME_LEN),
  .OUT_W    (OUT_W),
  .ENERGY_W (ENERGY_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .energy    (energy),
  .frame_done(frame_done)
);

// File: tb/frame_preproc_tb_top.sv
module frame_preproc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SPACING    = 8;
  localparam int SEG_LEN    = 40;
  localparam int NSEG       = 11;
  // each row: offset, slope per sample, alternating amplitude
  localparam int SEG_TAB [NSEG][3] = '{
    '{100, 0, 0}, '{-300, 7, 0}, '{0, 0, 2047}, '{-1, 0, 2047},
    '{500, -20, 300}, '{0, 3, 50}, '{-1500, 0, 10}, '{2000, -50, 0},
    '{0, 0, 0}, '{-800, 40, 900}, '{7, 0, 1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;
  logic [51:0] energy;
  logic        frame_done;

  int checks = 0, fails = 0;
  longint hist [0:1023];
  int nsamp = 0, out_cnt = 0, done_cnt = 0;
  bit bp_mode = 1'b0, stall_q = 1'b0, done_q = 1'b0;
  logic [23:0] stall_data;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_preproc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .energy(energy), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mq(int f);
    longint sm = 0;
    for (int i = 0; i < 200; i++) sm += hist[80*f + i];
    return (sm * 83886 + 32768) >>> 16;
  endfunction

  function automatic longint sval(int f, int n, longint m);
    return hist[80*f + n] * 256 - m;
  endfunction

  function automatic longint exp_y(int f, int n);
    longint m = mq(f);
    longint s = sval(f, n, m);
    longint p = (n == 0) ? 0 : sval(f, n - 1, m);
    return s - ((248 * p + 128) >>> 8);
  endfunction

  function automatic longint exp_e(int f);
    longint m = mq(f);
    longint e = 0;
    for (int n = 0; n < 200; n++) e += sval(f, n, m) * sval(f, n, m);
    return e;
  endfunction

  task automatic drive_sample(input int v);
    int c = (v > 2047) ? 2047 : ((v < -2048) ? -2048 : v);
    @(posedge clk); #1;
    in_valid  = 1'b1;
    in_sample = 12'(c);
    hist[nsamp] = longint'(c);
    nsamp++;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (SPACING - 2) @(posedge clk);
  endtask

  // ready pattern, updated just after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      stall_q = 1'b0;
      done_q  = 1'b0;
    end else begin
      if (stall_q)
        chk(out_valid && out_data == stall_data, "R7 held beat",
            longint'($signed(out_data)), longint'($signed(stall_data)));
      stall_q    = out_valid && !out_ready;
      stall_data = out_data;
      if (frame_done) begin
        chk(energy == 52'(exp_e(done_cnt)), "R5 energy", longint'(energy), exp_e(done_cnt));
        chk(out_valid && (out_cnt % 200 == 199), "R8 done with last beat",
            longint'(out_cnt % 200), 199);
        chk(!done_q, "R8 single-cycle done", 1, 0);
        chk(nsamp >= 200 + 80*done_cnt && nsamp < 280 + 80*done_cnt,
            "R1 R2 frame timing", nsamp, 200 + 80*done_cnt);
        done_cnt++;
      end
      done_q = frame_done;
      if (out_valid && out_ready) begin
        chk(longint'($signed(out_data)) == exp_y(out_cnt / 200, out_cnt % 200),
            "R3 R4 R6 beat", longint'($signed(out_data)), exp_y(out_cnt / 200, out_cnt % 200));
        out_cnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(!out_valid && !frame_done && energy == '0, "R9 reset state", longint'(out_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6, back-pressure R7 in later frames
    for (int sg = 0; sg < NSEG; sg++) begin
      if (sg == 7) bp_mode = 1'b1;
      for (int i = 0; i < SEG_LEN; i++)
        drive_sample(SEG_TAB[sg][0] + SEG_TAB[sg][1] * i +
                     ((i % 2 == 1) ? SEG_TAB[sg][2] : -SEG_TAB[sg][2]));
    end
    repeat (900) @(posedge clk);
    @(negedge clk);
    chk(done_cnt == 4, "R1 frame count", done_cnt, 4);
    chk(out_cnt == 800, "R6 beat count", out_cnt, 800);
    bp_mode = 1'b0;

    // mid-stream reset restarts priming (R9, R1), extreme values (R3 R5)
    for (int i = 0; i < 30; i++) drive_sample(5);
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    chk(!out_valid && !frame_done && energy == '0, "R9 reset mid-stream", longint'(energy), 0);
    nsamp = 0; out_cnt = 0; done_cnt = 0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 199; i++) drive_sample(-2048);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(done_cnt == 0 && out_cnt == 0 && !out_valid, "R1 no frame at 199 samples", done_cnt, 0);
    drive_sample(-2048);
    for (int i = 0; i < 80; i++) drive_sample(2047);
    repeat (900) @(posedge clk);
    @(negedge clk);
    chk(done_cnt == 2, "R1 frames after restart", done_cnt, 2);
    chk(out_cnt == 400, "R6 beats after restart", out_cnt, 400);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule